// File: doc/BRIEF.md
# Ultrasonic Time-of-Flight Measurement Sequencer

This block runs one ultrasonic time-of-flight measurement each time it receives a trigger pulse. It steps through a fixed chain of phases: it sends a burst, optionally waits with the receive path powered down, lets the common-mode reference settle, autozeroes the receiver, listens for the echo, and closes with a short tail. At the end it raises a one-cycle completion flag. Each phase lasts a programmed number of ticks of one of two time bases. The base unit T0 is the input clock, optionally divided by `T0_DIV`. The transmit period T1 is a whole number of T0 units.

The block drives a start pulse that marks the opening of the burst, an analog-enable output, a receive-chain enable and a phase code. All configuration arrives as static inputs, held steady for the whole measurement. In the long-wait variant the analog front end stays dark after transmit for a wait whose length comes from a 10-bit timing field. A force-short input removes that wait. The listen and autozero lengths scale by powers of two.

States and transitions of the machine:
- IDLE goes to XMIT when a trigger arrives. If the burst count is zero it goes straight to BLANK or SETTLE instead.
- XMIT goes to BLANK when the wait is in force, and to SETTLE otherwise.
- BLANK goes to SETTLE.
- SETTLE goes to AZERO.
- AZERO goes to LISTEN.
- LISTEN goes to TAIL.
- TAIL goes to DONE.
- DONE goes back to IDLE unconditionally.

Every transition except DONE→IDLE fires on the last tick of the current phase.

Top module: `tof_seq`

## Requirements
- R1: While reset is held and just after it is released, `phase_o` is 0 (IDLE) and `start_o`, `afe_en_o`, `rx_en_o` and `done_o` are all low.
- R2: A trigger sampled in IDLE starts the measurement at the next clock. The phase codes are IDLE=0, XMIT=1, BLANK=2, SETTLE=3, AZERO=4, LISTEN=5, TAIL=6 and DONE=7, and they are visited in increasing order. Skipped phases are never shown.
- R3: XMIT lasts `num_tx_i` T1 periods, where one T1 period is `t1_div_i`+1 T0 units. A burst count of 0 skips XMIT entirely.
- R4: `start_o` is high only in XMIT, from its first cycle, for min(`num_tx_i`, 3) T1 periods.
- R5: One T0 unit is 1 clock when `clkdiv_sel_i` is 0 and `T0_DIV` clocks (default 4) when it is 1.
- R6: When `blank_en_i` is 1, `force_short_i` is 0 and `timing_i` is above 30, BLANK follows XMIT and lasts (`timing_i` − 30) × 8 T0. A `timing_i` of 30 or less gives no BLANK phase. `afe_en_o` and `rx_en_o` are low throughout BLANK.
- R7: With `force_short_i` at 1, BLANK is never entered, whatever `blank_en_i` and `timing_i` hold.
- R8: SETTLE lasts 128 T0.
- R9: AZERO lasts 64 × 2^`az_exp_i` T0.
- R10: LISTEN lasts 128 × 2^`tmo_exp_i` T0.
- R11: TAIL lasts one T1 period. It is followed by exactly one cycle of DONE with `done_o` high, and then by IDLE.
- R12: A trigger that arrives while a measurement is running changes no phase length, and it does not start a second measurement afterwards.
- R13: `afe_en_o` is high in XMIT, SETTLE, AZERO, LISTEN and TAIL. `rx_en_o` is high only in SETTLE, AZERO and LISTEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Measurement trigger, sampled in IDLE |
| clkdiv_sel_i | input | 1 | 1 selects T0 = `T0_DIV` clocks, 0 selects T0 = 1 clock |
| t1_div_i | input | 4 | T1 length minus one, in T0 units |
| num_tx_i | input | 5 | Burst length in T1 periods |
| blank_en_i | input | 1 | Enables the powered-down wait after transmit |
| force_short_i | input | 1 | Forces the short sequence (no wait) |
| timing_i | input | 10 | Wait timing field |
| az_exp_i | input | 2 | Autozero length exponent |
| tmo_exp_i | input | 2 | Listen length exponent |
| start_o | output | 1 | Start pulse at the opening of transmit |
| afe_en_o | output | 1 | Analog front-end enable |
| rx_en_o | output | 1 | Receive-chain enable |
| phase_o | output | 3 | Current phase code |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The phase code changes one clock after the trigger edge, because a single state register lies between them. Each later phase boundary is due exactly its length in clocks after the previous one, because both dividers restart at every phase entry. The bench drives the trigger and samples on falling edges, so every sample stands for exactly one clock. For each phase it counts the samples that carry that phase's code, and it compares the count with the product of the tick count, the T0 divide and the T1 divide, computed from the configuration. The same counts are taken for the start, analog and receive enables, and DONE must occupy exactly one sample before IDLE returns.

// File: rtl/tof_seq_pkg.sv
package tof_seq_pkg;

    // Phase codes; the numeric order is the order the phases are visited.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_XMIT   = 3'd1,
        PH_BLANK  = 3'd2,
        PH_SETTLE = 3'd3,
        PH_AZERO  = 3'd4,
        PH_LISTEN = 3'd5,
        PH_TAIL   = 3'd6,
        PH_DONE   = 3'd7
    } phase_e;

    // Which time base paces a phase counter.
    typedef enum logic {
        BASE_T0 = 1'b0,
        BASE_T1 = 1'b1
    } tbase_e;

endpackage

// File: rtl/tof_tick_gen.sv
// Produces the T0 and T1 enable ticks. Both dividers restart on demand so
// every phase begins on a fresh T0 and T1 boundary.
module tof_tick_gen #(
    parameter int T0_DIV    = 4,
    parameter int T1_DIV_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                div_sel,
    input  logic [T1_DIV_W-1:0] t1_div,
    output logic                t0_tick,
    output logic                t1_tick
);
    localparam int C0_W = (T0_DIV > 1) ? $clog2(T0_DIV) : 1;

    logic [C0_W-1:0]     c0_q;
    logic [C0_W-1:0]     c0_last;
    logic [T1_DIV_W-1:0] c1_q;

    // Last count of the T0 divider: 0 for the undivided clock.
    assign c0_last = div_sel ? C0_W'(T0_DIV - 1) : '0;
    assign t0_tick = (c0_q == c0_last);
    assign t1_tick = t0_tick && (c1_q == t1_div);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0_q <= '0;
        end else if (restart || t0_tick) begin
            c0_q <= '0;
        end else begin
            c0_q <= c0_q + C0_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1_q <= '0;
        end else if (restart) begin
            c1_q <= '0;
        end else if (t0_tick) begin
            if (c1_q == t1_div) begin
                c1_q <= '0;
            end else begin
                c1_q <= c1_q + T1_DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/tof_phase_len.sv
// Combinational length and time base of each phase, from the configuration.
module tof_phase_len
    import tof_seq_pkg::*;
#(
    parameter int LEN_W        = 13,
    parameter int NUM_TX_W     = 5,
    parameter int TIMING_W     = 10,
    parameter int AZ_EXP_W     = 2,
    parameter int TMO_EXP_W    = 2,
    parameter int BLANK_OFFSET = 30,
    parameter int BLANK_MULT   = 8,
    parameter int SETTLE_T0    = 128,
    parameter int AZ_BASE      = 64,
    parameter int LISTEN_BASE  = 128
) (
    input  phase_e               phase,
    input  logic [NUM_TX_W-1:0]  num_tx,
    input  logic [TIMING_W-1:0]  timing,
    input  logic [AZ_EXP_W-1:0]  az_exp,
    input  logic [TMO_EXP_W-1:0] tmo_exp,
    output logic [LEN_W-1:0]     len,
    output tbase_e               base
);
    always_comb begin
        len  = LEN_W'(1);
        base = BASE_T0;
        unique case (phase)
            PH_XMIT: begin
                len  = LEN_W'(num_tx);
                base = BASE_T1;
            end
            PH_BLANK: begin
                len = (LEN_W'(timing) - LEN_W'(BLANK_OFFSET)) * LEN_W'(BLANK_MULT);
            end
            PH_SETTLE: begin
                len = LEN_W'(SETTLE_T0);
            end
            PH_AZERO: begin
                len = LEN_W'(AZ_BASE) << az_exp;
            end
            PH_LISTEN: begin
                len = LEN_W'(LISTEN_BASE) << tmo_exp;
            end
            PH_TAIL: begin
                len  = LEN_W'(1);
                base = BASE_T1;
            end
            default: begin
                len  = LEN_W'(1);
                base = BASE_T0;
            end
        endcase
    end

endmodule

// File: rtl/tof_phase_timer.sv
// Counts ticks inside one phase and flags the final tick.
module tof_phase_timer #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] count,
    output logic             last
);
    assign last = tick && (count == (len - LEN_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + LEN_W'(1);
        end
    end

endmodule

// File: rtl/tof_seq.sv
module tof_seq
    import tof_seq_pkg::*;
#(
    parameter int T0_DIV       = 4,
    parameter int T1_DIV_W     = 4,
    parameter int NUM_TX_W     = 5,
    parameter int TIMING_W     = 10,
    parameter int AZ_EXP_W     = 2,
    parameter int TMO_EXP_W    = 2,
    parameter int BLANK_OFFSET = 30,
    parameter int BLANK_MULT   = 8,
    parameter int SETTLE_T0    = 128,
    parameter int AZ_BASE      = 64,
    parameter int LISTEN_BASE  = 128,
    parameter int START_MAX    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_i,
    input  logic                 clkdiv_sel_i,
    input  logic [T1_DIV_W-1:0]  t1_div_i,
    input  logic [NUM_TX_W-1:0]  num_tx_i,
    input  logic                 blank_en_i,
    input  logic                 force_short_i,
    input  logic [TIMING_W-1:0]  timing_i,
    input  logic [AZ_EXP_W-1:0]  az_exp_i,
    input  logic [TMO_EXP_W-1:0] tmo_exp_i,
    output logic                 start_o,
    output logic                 afe_en_o,
    output logic                 rx_en_o,
    output logic [2:0]           phase_o,
    output logic                 done_o
);
    // Longest phase in ticks sets the counter width.
    localparam int TX_MAX   = (1 << NUM_TX_W) - 1;
    localparam int WAIT_MAX = ((1 << TIMING_W) - 1 - BLANK_OFFSET) * BLANK_MULT;
    localparam int AZ_MAX   = AZ_BASE << ((1 << AZ_EXP_W) - 1);
    localparam int LS_MAX   = LISTEN_BASE << ((1 << TMO_EXP_W) - 1);
    localparam int MAX_A    = (TX_MAX > WAIT_MAX) ? TX_MAX : WAIT_MAX;
    localparam int MAX_B    = (AZ_MAX > LS_MAX) ? AZ_MAX : LS_MAX;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int LEN_MAX  = (MAX_C > SETTLE_T0) ? MAX_C : SETTLE_T0;
    localparam int LEN_W    = $clog2(LEN_MAX + 1);

    phase_e            state_q;
    phase_e            state_d;
    phase_e            after_xmit;
    tbase_e            cur_base;
    logic [LEN_W-1:0]  cur_len;
    logic [LEN_W-1:0]  cur_count;
    logic              cur_last;
    logic              cur_tick;
    logic              t0_tick;
    logic              t1_tick;
    logic              restart;
    logic              blank_on;
    logic              xmit_empty;

    // Configuration decode: is the long wait in force, is the burst empty.
    assign blank_on   = blank_en_i && !force_short_i &&
                        (timing_i > TIMING_W'(BLANK_OFFSET));
    assign xmit_empty = (num_tx_i == '0);
    assign after_xmit = blank_on ? PH_BLANK : PH_SETTLE;

    tof_tick_gen #(
        .T0_DIV   (T0_DIV),
        .T1_DIV_W (T1_DIV_W)
    ) ticks_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_sel (clkdiv_sel_i),
        .t1_div  (t1_div_i),
        .t0_tick (t0_tick),
        .t1_tick (t1_tick)
    );

    tof_phase_len #(
        .LEN_W        (LEN_W),
        .NUM_TX_W     (NUM_TX_W),
        .TIMING_W     (TIMING_W),
        .AZ_EXP_W     (AZ_EXP_W),
        .TMO_EXP_W    (TMO_EXP_W),
        .BLANK_OFFSET (BLANK_OFFSET),
        .BLANK_MULT   (BLANK_MULT),
        .SETTLE_T0    (SETTLE_T0),
        .AZ_BASE      (AZ_BASE),
        .LISTEN_BASE  (LISTEN_BASE)
    ) len_i (
        .phase   (state_q),
        .num_tx  (num_tx_i),
        .timing  (timing_i),
        .az_exp  (az_exp_i),
        .tmo_exp (tmo_exp_i),
        .len     (cur_len),
        .base    (cur_base)
    );

    assign cur_tick = (cur_base == BASE_T1) ? t1_tick : t0_tick;

    tof_phase_timer #(
        .LEN_W (LEN_W)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (cur_tick),
        .len   (cur_len),
        .count (cur_count),
        .last  (cur_last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (trig_i) begin
                    state_d = xmit_empty ? after_xmit : PH_XMIT;
                end
            end
            PH_XMIT: begin
                if (cur_last) begin
                    state_d = after_xmit;
                end
            end
            PH_BLANK: begin
                if (cur_last) begin
                    state_d = PH_SETTLE;
                end
            end
            PH_SETTLE: begin
                if (cur_last) begin
                    state_d = PH_AZERO;
                end
            end
            PH_AZERO: begin
                if (cur_last) begin
                    state_d = PH_LISTEN;
                end
            end
            PH_LISTEN: begin
                if (cur_last) begin
                    state_d = PH_TAIL;
                end
            end
            PH_TAIL: begin
                if (cur_last) begin
                    state_d = PH_DONE;
                end
            end
            PH_DONE: begin
                state_d = PH_IDLE;
            end
            default: begin
                state_d = PH_IDLE;
            end
        endcase
    end

    // Dividers and the phase counter restart in IDLE and on every phase change.
    assign restart = (state_q == PH_IDLE) || (state_d != state_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        start_o  = 1'b0;
        afe_en_o = 1'b0;
        rx_en_o  = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
            end
            PH_XMIT: begin
                afe_en_o = 1'b1;
                start_o  = (cur_count < LEN_W'(START_MAX));
            end
            PH_BLANK: begin
            end
            PH_SETTLE, PH_AZERO, PH_LISTEN: begin
                afe_en_o = 1'b1;
                rx_en_o  = 1'b1;
            end
            PH_TAIL: begin
                afe_en_o = 1'b1;
            end
            PH_DONE: begin
                done_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign phase_o = state_q;

endmodule

// File: rtl/tof_seq_chk.sv
module tof_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_i,
    input logic       start_o,
    input logic       afe_en_o,
    input logic       rx_en_o,
    input logic [2:0] phase_o,
    input logic       done_o
);
    // R2
    trig_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd0 && trig_i) |=> (phase_o != 3'd0));

    // R4
    start_in_xmit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (phase_o == 3'd1));

    // R6
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd2) |-> (!afe_en_o && !rx_en_o));

    // R11
    done_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(phase_o) == 3'd6));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && phase_o == 3'd0));

    // R12
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 3'd0 && phase_o != 3'd1) |=> (phase_o != 3'd1));

    // R13
    rx_needs_afe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_o |-> afe_en_o);

endmodule

bind tof_seq tof_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_i),
    .start_o  (start_o),
    .afe_en_o (afe_en_o),
    .rx_en_o  (rx_en_o),
    .phase_o  (phase_o),
    .done_o   (done_o)
);

// File: tb/tof_seq_tb_top.sv
`timescale 1ns/1ps
module tof_seq_tb_top;
    localparam int T0_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic       sel = 1'b0;
    logic [3:0] t1d = '0;
    logic [4:0] ntx = '0;
    logic       blk = 1'b0;
    logic       frc = 1'b0;
    logic [9:0] tim = '0;
    logic [1:0] aze = '0;
    logic [1:0] tme = '0;
    logic       start_w, afe_w, rx_w, done_w;
    logic [2:0] phase_w;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    tof_seq #(.T0_DIV(T0_DIV)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_i        (trig),
        .clkdiv_sel_i  (sel),
        .t1_div_i      (t1d),
        .num_tx_i      (ntx),
        .blank_en_i    (blk),
        .force_short_i (frc),
        .timing_i      (tim),
        .az_exp_i      (aze),
        .tmo_exp_i     (tme),
        .start_o       (start_w),
        .afe_en_o      (afe_w),
        .rx_en_o       (rx_w),
        .phase_o       (phase_w),
        .done_o        (done_w)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (ntx=%0d t1d=%0d sel=%0d blk=%0d frc=%0d tim=%0d aze=%0d tme=%0d)",
                     tag, act, exp, ntx, t1d, sel, blk, frc, tim, aze, tme);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(input int a_ntx, input int a_t1d, input int a_sel,
                       input int a_blk, input int a_frc, input int a_tim,
                       input int a_aze, input int a_tme, input bit retrig);
        int dur[8];
        int n_st = 0, n_afe = 0, n_rx = 0, first, d0, t1c, wt, stx, idle_bad;
        @(negedge clk);
        ntx = 5'(a_ntx); t1d = 4'(a_t1d); sel = a_sel[0]; blk = a_blk[0];
        frc = a_frc[0]; tim = 10'(a_tim); aze = 2'(a_aze); tme = 2'(a_tme);
        for (int i = 0; i < 8; i++) dur[i] = 0;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        first = int'(phase_w);
        for (int n = 0; n < 60000; n++) begin
            if (phase_w == 3'd0) break;
            dur[phase_w]++;
            n_st  += int'(start_w);
            n_afe += int'(afe_w);
            n_rx  += int'(rx_w);
            trig = (retrig && n == 40);
            @(negedge clk);
        end
        trig = 1'b0;
        // Expected lengths in clocks, from the requirements.
        d0  = a_sel ? T0_DIV : 1;
        t1c = d0 * (a_t1d + 1);
        wt  = (a_blk && !a_frc && a_tim > 30) ? (a_tim - 30) * 8 * d0 : 0;
        stx = (a_ntx < 3) ? a_ntx : 3;
        chk("R2 first phase", first, (a_ntx != 0) ? 1 : ((wt != 0) ? 2 : 3));
        chk("R3 xmit clocks", dur[1], a_ntx * t1c);
        chk("R4 start clocks", n_st, stx * t1c);
        chk(a_frc ? "R7 wait clocks" : "R6 wait clocks", dur[2], wt);
        chk(a_sel ? "R5 settle clocks" : "R8 settle clocks", dur[3], 128 * d0);
        chk("R9 autozero clocks", dur[4], (64 << a_aze) * d0);
        chk("R10 listen clocks", dur[5], (128 << a_tme) * d0);
        chk("R11 tail clocks", dur[6], t1c);
        chk("R11 done cycles", dur[7], 1);
        chk("R13 afe clocks", n_afe, a_ntx * t1c + (128 + (64 << a_aze) + (128 << a_tme)) * d0 + t1c);
        chk("R13 rx clocks", n_rx, (128 + (64 << a_aze) + (128 << a_tme)) * d0);
        if (retrig) begin
            idle_bad = 0;
            for (int k = 0; k < 4; k++) begin
                if (phase_w != 3'd0) idle_bad++;
                @(negedge clk);
            end
            chk("R12 no restart after busy trigger", idle_bad, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held and right after release.
        chk("R1 phase in reset", int'(phase_w), 0);
        chk("R1 outputs in reset", int'({start_w, afe_w, rx_w, done_w}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 phase after reset", int'(phase_w), 0);
        chk("R1 outputs after reset", int'({start_w, afe_w, rx_w, done_w}), 0);

        // Burst length, T1 divide and T0 divide sweep.
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 3; d++)
                for (int n = 0; n < 6; n++)
                    run(n, d, s, 0, 0, 0, 0, 0, 1'b0);

        // Wait field, enable and force-short sweep.
        for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++)
                foreach (tim_list[i])
                    run(2, 1, 0, b, f, tim_list[i], 0, 0, 1'b0);
        run(0, 0, 0, 1, 0, 33, 0, 0, 1'b0);
        run(4, 0, 1, 1, 0, 45, 1, 0, 1'b0);

        // Power-of-two scaled autozero and listen sweep.
        for (int a = 0; a < 4; a++)
            for (int t = 0; t < 4; t++)
                run(1, 0, 0, 0, 0, 0, a, t, 1'b0);

        // R12: triggers while busy.
        run(3, 1, 0, 0, 0, 0, 0, 0, 1'b1);
        run(5, 0, 1, 1, 0, 40, 0, 1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    int tim_list[6] = '{0, 29, 30, 31, 33, 45};

endmodule